// File: doc/BRIEF.md
# Page-Mode Asynchronous Static Memory Controller

This block connects an internal requester to an external asynchronous static memory. The memory has a full-width address bus that is never multiplexed, a bidirectional data bus, and three active-low strobes: chip select, output enable and write strobe. On the internal side the requester presents an address, a write flag and write data together with a request. The controller signals completion with a one-cycle ready pulse, and for reads it returns the data at the same time.

The memory needs no refresh, so every cycle is available for requests. Access times are given in nanoseconds and rounded up to whole clock cycles. The upper address bits select a page and the lower bits select a word inside it. After a read, the controller keeps chip select and output enable asserted and remembers which page is open. A later read in that page only waits for the short in-page access time. A read to any other page, or any read that follows a write, waits for the full random-access time.

The data bus is modelled as separate output data, input data and drive-enable signals. The strobe sequence keeps the controller's drivers and the memory's output drivers from ever driving the bus at the same time.

Top module: `sramc_page_ctrl`

## Requirements
- R1: During and after reset, chip select, output enable and write strobe are all high (inactive), drive enable is low and ready is low.
- R2: A read that misses the open page holds its address for RAND_CYC cycles before the data is sampled. Ready rises RAND_CYC cycles after the accepting edge. RAND_CYC = ceil(T_RAND_NS / CLK_NS), with a minimum of 1; the defaults give 4.
- R3: A read whose upper address bits match the open page waits only PAGE_CYC = ceil(T_PAGE_NS / CLK_NS) cycles (2 by default). Chip select and output enable stay low between the two reads.
- R4: A read whose upper address bits differ from the open page waits the full RAND_CYC cycles and then becomes the open page.
- R5: A write closes the open page, so the next read waits RAND_CYC cycles even if it targets the same page.
- R6: A write holds output enable high and chip select low, and drives the data while the write strobe is low for exactly WE_CYC cycles. The data stays driven and unchanged for one cycle after the strobe rises. Ready rises WE_CYC+2 cycles after the accepting edge.
- R7: Drive enable is never high while output enable is low. At least one cycle with output enable high comes before drive enable rises.
- R8: Ready is high for exactly one cycle per accepted request, and is never high in two consecutive cycles.
- R9: Read data changes only when a read completes. It holds its value through later writes and idle cycles.
- R10: A request held high in the cycle where ready is high is accepted at the next edge, with no idle cycle in between.
- R11: The page offset is the low log2(PAGE_WORDS) address bits (8 bits for 256 words; 256, 512 and 1024 are supported). With the defaults, addresses 0x100 and 0x1FF share a page, and 0x200 starts a new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request; accepted at an edge where the controller is idle |
| req_wr | input | 1 | 1 = write, 0 = read; sampled on acceptance |
| req_addr | input | ADDR_W | Word address; sampled on acceptance |
| req_wdata | input | DATA_W | Write data; sampled on acceptance |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Data from the latest completed read |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dout | output | DATA_W | Data driven toward the memory |
| mem_din | input | DATA_W | Data returned by the memory |
| mem_drive | output | 1 | Enables the controller's data drivers |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |

## Verification
The hardest case to reach is a page-hit read that is accepted in the very cycle the previous read reports ready. The request must already be held high with a new in-page address, so the bus stays in read mode with no gap. The bench does this by raising the next address while the first read is still waiting. Its memory model returns a poison value whenever data is sampled before the page-select bits or the word address have been stable for the required number of cycles. As a result, both a shortened wait and a false page hit show up as wrong data, not just as a latency difference.

// File: rtl/sramc_pkg.sv
// Shared types and helpers for the page-mode static memory controller.
// Assumes clock periods and access times are given in whole nanoseconds.
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WSET   = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WHOLD  = 3'd4
    } sramc_state_e;

    // Round an access time up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/sramc_wait_cnt.sv
// Loadable down-counter that times a memory access phase.
// Assumes load values lie between 1 and MAX_VAL; last flags the final cycle.
module sramc_wait_cnt #(
    parameter int unsigned MAX_VAL = 4,
    localparam int unsigned CNT_W  = $clog2(MAX_VAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new wait or count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNT_W'(1));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_VAL));

endmodule

// File: rtl/sramc_page_track.sv
// Remembers the page left open by the last read and reports hits.
// Assumes the caller clears it on writes and on reads to another page.
module sramc_page_track #(
    parameter int unsigned TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] look_tag,
    input  logic             clear,
    input  logic             open,
    input  logic [TAG_W-1:0] open_tag,
    output logic             hit
);

    logic             valid_q;
    logic [TAG_W-1:0] tag_q;

    // Record or forget the open page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (open) begin
            valid_q <= 1'b1;
            tag_q   <= open_tag;
        end else if (clear) begin
            valid_q <= 1'b0;
        end
    end

    assign hit = valid_q && (tag_q == look_tag);

endmodule

// File: rtl/sramc_seq.sv
// Strobe sequencer: runs the read and write cycles on the memory pins.
// Assumes the wait counter is loaded by the top on acceptance and in WSET.
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cnt_last,
    input  logic [DATA_W-1:0] mem_din,
    output logic              accept_rd,
    output logic              accept_wr,
    output logic              in_wset,
    output logic              read_done,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_drive,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    sramc_state_e      state_q;
    logic              ready_q, drive_q, ce_n_q, oe_n_q, we_n_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;

    assign accept_rd = (state_q == ST_IDLE) && req && !req_wr;
    assign accept_wr = (state_q == ST_IDLE) && req &&  req_wr;
    assign in_wset   = (state_q == ST_WSET);
    assign read_done = (state_q == ST_READ) && cnt_last;

    // Step through the access phases and register every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ready_q <= 1'b0;
            drive_q <= 1'b0;
            ce_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            we_n_q  <= 1'b1;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            ready_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        addr_q <= req_addr;
                        ce_n_q <= 1'b0;
                        if (req_wr) begin
                            oe_n_q  <= 1'b1;
                            wdata_q <= req_wdata;
                            state_q <= ST_WSET;
                        end else begin
                            oe_n_q  <= 1'b0;
                            state_q <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (cnt_last) begin
                        rdata_q <= mem_din;
                        ready_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_WSET: begin
                    we_n_q  <= 1'b0;
                    drive_q <= 1'b1;
                    state_q <= ST_WPULSE;
                end
                ST_WPULSE: begin
                    if (cnt_last) begin
                        we_n_q  <= 1'b1;
                        state_q <= ST_WHOLD;
                    end
                end
                ST_WHOLD: begin
                    drive_q <= 1'b0;
                    ce_n_q  <= 1'b1;
                    ready_q <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ready     = ready_q;
    assign rdata     = rdata_q;
    assign mem_addr  = addr_q;
    assign mem_dout  = wdata_q;
    assign mem_drive = drive_q;
    assign mem_ce_n  = ce_n_q;
    assign mem_oe_n  = oe_n_q;
    assign mem_we_n  = we_n_q;

    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_q && !oe_n_q));
    p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_q) |-> $past(oe_n_q));
    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> !ready_q);
    p_we_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_q |-> (oe_n_q && drive_q && !ce_n_q));
    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n_q) |-> (drive_q && $stable(wdata_q)));
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_READ) |=> $stable(rdata_q));

endmodule

// File: rtl/sramc_page_ctrl.sv
// Top of the page-mode asynchronous static memory controller.
// Assumes PAGE_WORDS is 256, 512 or 1024 and the requester holds req until accepted.
module sramc_page_ctrl
    import sramc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned PAGE_WORDS = 256,
    parameter int unsigned CLK_NS     = 20,
    parameter int unsigned T_RAND_NS  = 70,
    parameter int unsigned T_PAGE_NS  = 30,
    parameter int unsigned WE_CYC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_drive,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    localparam int unsigned OFFS_W   = $clog2(PAGE_WORDS);
    localparam int unsigned TAG_W    = ADDR_W - OFFS_W;
    localparam int unsigned RAND_CYC = ns_to_cycles(T_RAND_NS, CLK_NS);
    localparam int unsigned PAGE_CYC = ns_to_cycles(T_PAGE_NS, CLK_NS);
    localparam int unsigned WE_LEN   = (WE_CYC == 0) ? 1 : WE_CYC;
    localparam int unsigned MAX_A    = (RAND_CYC > PAGE_CYC) ? RAND_CYC : PAGE_CYC;
    localparam int unsigned MAX_CYC  = (MAX_A > WE_LEN) ? MAX_A : WE_LEN;
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    logic             accept_rd, accept_wr, in_wset, read_done, cnt_last, hit;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;

    // Choose the wait for the phase that is starting.
    always_comb begin
        cnt_load = accept_rd || in_wset;
        if (in_wset)  cnt_val = CNT_W'(WE_LEN);
        else if (hit) cnt_val = CNT_W'(PAGE_CYC);
        else          cnt_val = CNT_W'(RAND_CYC);
    end

    sramc_page_track #(.TAG_W(TAG_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_tag (req_addr[ADDR_W-1:OFFS_W]),
        .clear    (accept_wr || (accept_rd && !hit)),
        .open     (read_done),
        .open_tag (mem_addr[ADDR_W-1:OFFS_W]),
        .hit      (hit)
    );

    sramc_wait_cnt #(.MAX_VAL(MAX_CYC)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .last     (cnt_last)
    );

    sramc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cnt_last  (cnt_last),
        .mem_din   (mem_din),
        .accept_rd (accept_rd),
        .accept_wr (accept_wr),
        .in_wset   (in_wset),
        .read_done (read_done),
        .ready     (ready),
        .rdata     (rdata),
        .mem_addr  (mem_addr),
        .mem_dout  (mem_dout),
        .mem_drive (mem_drive),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n)
    );

    // A page hit only starts while the bus is still held in read mode.
    p_hit_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_rd && hit) |-> (!mem_ce_n && !mem_oe_n));

endmodule

// File: tb/sramc_page_ctrl_bench.sv
// Directed bench: models the memory's access timing and checks each scenario.
module sramc_page_ctrl_bench;

    localparam int AW = 12, DW = 8, PW = 256, CK = 20;
    localparam int TR = 70, TP = 30, WEC = 2;
    localparam int RC = (TR + CK - 1) / CK;   // expected random wait
    localparam int PC = (TP + CK - 1) / CK;   // expected in-page wait
    localparam int OB = $clog2(PW);

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ready, mem_drive, mem_ce_n, mem_oe_n, mem_we_n;
    logic [DW-1:0] rdata, mem_dout, mem_din;
    logic [AW-1:0] mem_addr;

    int n_chk = 0, n_bad = 0;

    always #(CK/2) clk = ~clk;

    sramc_page_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_WORDS(PW), .CLK_NS(CK),
                      .T_RAND_NS(TR), .T_PAGE_NS(TP), .WE_CYC(WEC)) u_sramc_page_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .rdata(rdata), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_drive(mem_drive),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n));

    // Memory model: poison data until the access time has elapsed.
    logic [DW-1:0] mem [1024];
    int            rand_age = 0, word_age = 0, we_len = 0, last_we_len = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] wr_data_l = '0;
    logic [AW-1:0] wr_addr_l = '0;
    logic          prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_ready = 1'b0;
    int            contention = 0, no_gap = 0, hold_bad = 0, dbl_ready = 0, n_ready = 0;

    assign mem_din = (!mem_ce_n && !mem_oe_n && rand_age >= RC && word_age >= PC)
                     ? mem[mem_addr[9:0]] : 8'hEE;

    always @(negedge clk) begin
        if (mem_ce_n || mem_oe_n) begin
            rand_age <= 0;
            word_age <= 0;
        end else begin
            if (rand_age == 0 || mem_addr[AW-1:OB] != prev_addr[AW-1:OB]) rand_age <= 1;
            else if (rand_age < 64) rand_age <= rand_age + 1;
            if (word_age == 0 || mem_addr != prev_addr) word_age <= 1;
            else if (word_age < 64) word_age <= word_age + 1;
        end
        prev_addr <= mem_addr;
        if (!mem_we_n) begin
            wr_data_l <= mem_dout;
            wr_addr_l <= mem_addr;
            we_len    <= we_len + 1;
        end else if (!prev_we_n) begin
            if (!mem_drive || mem_dout != wr_data_l) hold_bad <= hold_bad + 1;
            mem[wr_addr_l[9:0]] <= wr_data_l;
            last_we_len <= we_len;
            we_len      <= 0;
        end
        if (mem_drive && !mem_oe_n) contention <= contention + 1;
        if (mem_drive && !prev_oe_n) no_gap <= no_gap + 1;
        if (ready && prev_ready) dbl_ready <= dbl_ready + 1;
        if (ready) n_ready <= n_ready + 1;
        prev_we_n  <= mem_we_n;
        prev_oe_n  <= mem_oe_n;
        prev_ready <= ready;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Issue one request and count cycles from acceptance to ready.
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int lat);
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        lat = 0;
        while (!ready && lat < 50) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        chk(!mem_drive && !ready, "R1 drive/ready", {mem_drive, ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && !mem_drive && !ready, "R1 after release",
            {mem_ce_n, mem_oe_n, mem_drive, ready}, 4'b1100);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input int exp_lat, input string rq);
        int lat;
        issue(1'b0, a, '0, lat);
        chk(lat == exp_lat, {rq, " latency"}, lat, exp_lat);
        chk(rdata == mem[a[9:0]], {rq, " data"}, rdata, mem[a[9:0]]);
    endtask

    task automatic t_write_then_check(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lat;
        logic [DW-1:0] held;
        held = rdata;
        issue(1'b1, a, d, lat);
        chk(lat == WEC + 2, "R6 write latency", lat, WEC + 2);
        @(negedge clk);
        chk(last_we_len == WEC, "R6 strobe width", last_we_len, WEC);
        chk(hold_bad == 0, "R6 data hold", hold_bad, 0);
        chk(rdata == held, "R9 rdata held over write", rdata, held);
        chk(mem[a[9:0]] == d, "R6 stored", mem[a[9:0]], d);
    endtask

    // R10: second request held high and accepted at the ready edge.
    task automatic t_back_to_back(input logic [AW-1:0] a, input logic [AW-1:0] b);
        int gap;
        int first_seen;
        @(negedge clk);
        req = 1'b1; req_wr = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_addr = b;
        first_seen = 0;
        while (!ready && first_seen < 50) begin
            @(negedge clk);
            first_seen++;
        end
        chk(rdata == mem[a[9:0]], "R10 first data", rdata, mem[a[9:0]]);
        @(negedge clk);
        req = 1'b0;
        gap = 1;
        while (!ready && gap < 50) begin
            @(negedge clk);
            gap++;
        end
        chk(gap == 1 + PC, "R10 back-to-back spacing", gap, 1 + PC);
        chk(rdata == mem[b[9:0]], "R10 second data", rdata, mem[b[9:0]]);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = ((i * 7 + 3) & 8'hFF) == 8'hEE ? 8'h11 : 8'((i * 7 + 3) & 8'hFF);
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_read(12'h105, RC, "R2 random read");
        t_read(12'h1FF, PC, "R3 R11 page hit top word");
        t_read(12'h100, PC, "R3 R11 page hit bottom word");
        chk(!mem_ce_n && !mem_oe_n, "R3 bus held open", {mem_ce_n, mem_oe_n}, 0);
        t_read(12'h200, RC, "R4 R11 page miss");
        t_write_then_check(12'h210, 8'h5A);
        t_read(12'h210, RC, "R5 read after write");
        t_back_to_back(12'h211, 12'h212);
        t_write_then_check(12'h213, 8'hA7);
        t_read(12'h213, RC, "R5 same page after write");
        repeat (3) @(negedge clk);
        chk(contention == 0, "R7 no contention", contention, 0);
        chk(no_gap == 0, "R7 turnaround gap", no_gap, 0);
        chk(dbl_ready == 0, "R8 single-cycle ready", dbl_ready, 0);
        chk(n_ready == 10, "R8 one pulse per request", n_ready, 10);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule